// File: doc/BRIEF.md
# OSD Text Window Start Timer

This block sets where the text window of an on-screen display overlay begins on the screen, and whether the overlay runs at all. A core writes three byte-wide control registers through a paged write port. One register holds the master display switch. The other two hold the vertical and horizontal start positions together with two background style flags. The block counts scan lines from the rising edge of vertical sync and dot clocks from the rising edge of horizontal sync. It emits a one-clock strobe at the dot where the first character of the first character line begins.

The vertical position is counted in steps of four scan lines, and a zero vertical position is not allowed. The horizontal position is counted in units of two dot clocks and always carries a fixed offset of ten units. While the master switch is on, the block locks the position and style registers against writes. It also withholds its grant from core requests for the display RAM. The background style flags go straight to the pixel logic downstream. Neither sync input nor any output carries a data stream, so every pin is a plain level or strobe and there is no back-pressure.

Top module: `osd_window_timer`

## Requirements
- R1: After reset, the outputs are disp_en=0, vsa_bad=1, bg_fringe=0, bg_space_en=1, win_start=0 and ram_grant=0, and every register field is zero.
- R2: A write with reg_page=6 and reg_addr=5'h17 loads bit 0 of reg_wdata into the master switch, which drives disp_en. This write is accepted whether disp_en is 0 or 1.
- R3: A write with reg_page=6 and reg_addr=5'h10 loads reg_wdata[5:0] as the vertical start V and reg_wdata[6] as the fringe select, which drives bg_fringe (1=fringe, 0=box). The write is ignored while disp_en=1.
- R4: A write with reg_page=6 and reg_addr=5'h11 loads reg_wdata[5:0] as the horizontal start H and reg_wdata[6] as the space-blank disable. bg_space_en is the inverse of that bit, so 0 forces background off on spaces. The write is ignored while disp_en=1.
- R5: A write with any other page, or any other offset within page 6, changes no output.
- R6: The line count is the number of hsync rising edges seen since the last vsync rising edge. The strobe fires only on the line whose count equals 4*V.
- R7: On that line, win_start is high during the clock period that follows the (2*(10+H)+1)-th rising clock edge after the edge at which hsync is first sampled high.
- R8: win_start is exactly one clock wide, fires at most once per frame, and fires only while disp_en=1.
- R9: vsa_bad is 1 exactly when V=0, and no strobe fires while V=0.
- R10: ram_grant equals ram_req while disp_en=0 and is 0 while disp_en=1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_page | input | 3 | Register page of the write |
| reg_addr | input | 5 | Register offset within the page |
| reg_wdata | input | 8 | Write data |
| hsync | input | 1 | Horizontal sync, synchronous to clk, active high |
| vsync | input | 1 | Vertical sync, synchronous to clk, active high |
| ram_req | input | 1 | Core request for display RAM access |
| ram_grant | output | 1 | Core RAM access granted |
| disp_en | output | 1 | Master display switch state |
| vsa_bad | output | 1 | Vertical start is the illegal value zero |
| bg_fringe | output | 1 | Background mode: 1 fringe, 0 box of 7x9 dots |
| bg_space_en | output | 1 | Background allowed on space characters |
| win_start | output | 1 | One-clock strobe at the first character of the window |

## Verification
The checker checks these rules on every cycle: the strobe lasts one clock, it fires only when the switch was on and V was nonzero, the style and position outputs hold while the switch is on, and RAM access is never granted while the switch is on. The checker cannot see exact strobe placement, so only the bench's cycle model can show it. That covers the line selected by 4*V, the dot selected by 2*(10+H), and one strobe per frame over the swept start values. The bench scenarios also show that writes to foreign pages and offsets are dropped, that a zero vertical start stops the window from opening, and that the master switch can be cleared while locked.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;
  localparam int START_W  = 6;
  localparam int V_STEP   = 4;
  localparam int H_OFFSET = 10;
  localparam int H_UNIT   = 2;
  localparam int PAGE_W   = 3;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int FLAG_BIT = START_W;

  localparam int LINE_W = $clog2(V_STEP * (2 ** START_W)) + 1;
  localparam int DOT_W  = $clog2(H_UNIT * (H_OFFSET + 2 ** START_W)) + 1;

  localparam logic [PAGE_W-1:0] OSD_PAGE   = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_VERT   = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_HORZ   = 5'h11;
  localparam logic [ADDR_W-1:0] OFF_MASTER = 5'h17;

  typedef struct packed {
    logic               master;
    logic               fringe;
    logic               space_blank;
    logic [START_W-1:0] vstart;
    logic [START_W-1:0] hstart;
  } osd_cfg_t;
endpackage

// File: rtl/osd_edge_rise.sv
module osd_edge_rise #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= sig_in[i];
    end
    assign rise[i] = sig_in[i] & ~prev_q[i];
  end
endmodule

// File: rtl/osd_sat_counter.sv
module osd_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && (cnt != '1)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/osd_cfg_regs.sv
module osd_cfg_regs
  import osd_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output osd_cfg_t          cfg
);
  logic on_page;
  assign on_page = wr_en && (wr_page == OSD_PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (on_page) begin
      case (wr_addr)
        OFF_MASTER: cfg.master <= wr_data[0];
        OFF_VERT: if (!cfg.master) begin
          cfg.fringe <= wr_data[FLAG_BIT];
          cfg.vstart <= wr_data[START_W-1:0];
        end
        OFF_HORZ: if (!cfg.master) begin
          cfg.space_blank <= wr_data[FLAG_BIT];
          cfg.hstart      <= wr_data[START_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/osd_start_match.sv
module osd_start_match
  import osd_win_pkg::*;
#(
  parameter int VSTEP = V_STEP,
  parameter int HOFF  = H_OFFSET,
  parameter int HUNIT = H_UNIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  osd_cfg_t          cfg,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [DOT_W-1:0]  dot_cnt,
  output logic              strobe
);
  logic [LINE_W-1:0] v_tgt;
  logic [DOT_W-1:0]  h_tgt;
  logic              armed;
  logic              hit;

  assign v_tgt = LINE_W'(cfg.vstart) * LINE_W'(VSTEP);
  assign h_tgt = DOT_W'(HUNIT) * (DOT_W'(HOFF) + DOT_W'(cfg.hstart));
  assign armed = cfg.master && (cfg.vstart != '0);
  assign hit   = armed && (line_cnt == v_tgt) && (dot_cnt == h_tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= hit;
  end
endmodule

// File: rtl/osd_window_timer.sv
module osd_window_timer
  import osd_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [PAGE_W-1:0] reg_page,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              ram_req,
  output logic              ram_grant,
  output logic              disp_en,
  output logic              vsa_bad,
  output logic              bg_fringe,
  output logic              bg_space_en,
  output logic              win_start
);
  localparam int SYNC_N = 2;
  localparam int IDX_H  = 0;
  localparam int IDX_V  = 1;

  osd_cfg_t          cfg;
  logic [SYNC_N-1:0] sync_rise;
  logic [LINE_W-1:0] line_cnt;
  logic [DOT_W-1:0]  dot_cnt;

  osd_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_page(reg_page),
    .wr_addr(reg_addr), .wr_data(reg_wdata), .cfg(cfg)
  );

  osd_edge_rise #(.N(SYNC_N)) u_edges (
    .clk(clk), .rst_n(rst_n), .sig_in({vsync, hsync}), .rise(sync_rise)
  );

  osd_sat_counter #(.W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .clr(sync_rise[IDX_V]),
    .inc(sync_rise[IDX_H]), .cnt(line_cnt)
  );

  osd_sat_counter #(.W(DOT_W)) u_dot (
    .clk(clk), .rst_n(rst_n), .clr(sync_rise[IDX_H]),
    .inc(1'b1), .cnt(dot_cnt)
  );

  osd_start_match u_match (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .line_cnt(line_cnt),
    .dot_cnt(dot_cnt), .strobe(win_start)
  );

  assign disp_en     = cfg.master;
  assign vsa_bad     = (cfg.vstart == '0);
  assign bg_fringe   = cfg.fringe;
  assign bg_space_en = ~cfg.space_blank;
  assign ram_grant   = ram_req & ~cfg.master;
endmodule

// File: rtl/osd_window_timer_chk.sv
module osd_window_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic win_start,
  input logic disp_en,
  input logic vsa_bad,
  input logic bg_fringe,
  input logic bg_space_en,
  input logic ram_req,
  input logic ram_grant
);
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> !win_start); // R8

  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |-> $past(disp_en && !vsa_bad)); // R9

  AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |=> ($stable(bg_fringe) && $stable(bg_space_en) && $stable(vsa_bad))); // R3

  AST_RAM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> !ram_grant); // R10

  AST_RAM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en && ram_req) |-> ram_grant); // R10
endmodule

bind osd_window_timer osd_window_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .win_start(win_start), .disp_en(disp_en),
  .vsa_bad(vsa_bad), .bg_fringe(bg_fringe), .bg_space_en(bg_space_en),
  .ram_req(ram_req), .ram_grant(ram_grant)
);

// File: tb/osd_window_timer_bench.sv
`timescale 1ns/1ps
module osd_window_timer_bench;
  localparam int LINE_LEN = 200;
  localparam int WD_CYC   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [2:0] reg_page = '0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       hsync = 1'b0, vsync = 1'b0, ram_req = 1'b0;
  logic       ram_grant, disp_en, vsa_bad, bg_fringe, bg_space_en, win_start;

  int checks = 0, errors = 0, strobes = 0;
  bit done = 0;

  // reference model state
  int m_line = 0, m_dot = 0, m_v = 0, m_h = 0;
  bit m_ge = 0, m_fr = 0, m_sbd = 0, m_hs = 0, m_vs = 0, m_ws = 0;

  always #10 clk = ~clk;

  osd_window_timer u_osd_window_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_page(reg_page),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hsync(hsync), .vsync(vsync),
    .ram_req(ram_req), .ram_grant(ram_grant), .disp_en(disp_en),
    .vsa_bad(vsa_bad), .bg_fringe(bg_fringe), .bg_space_en(bg_space_en),
    .win_start(win_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_dot = 0; m_v = 0; m_h = 0;
      m_ge = 0; m_fr = 0; m_sbd = 0; m_hs = 0; m_vs = 0; m_ws = 0;
    end else begin
      bit lock;
      lock = m_ge;
      m_ws = m_ge && (m_v != 0) && (m_line == 4 * m_v) && (m_dot == 2 * (10 + m_h));
      if (vsync && !m_vs)      m_line = 0;
      else if (hsync && !m_hs) m_line++;
      if (hsync && !m_hs) m_dot = 0;
      else                m_dot++;
      m_vs = vsync; m_hs = hsync;
      if (reg_wr_en && reg_page == 3'd6) begin
        if (reg_addr == 5'h17) m_ge = reg_wdata[0];
        if (reg_addr == 5'h10 && !lock) begin m_v = reg_wdata[5:0]; m_fr = reg_wdata[6]; end
        if (reg_addr == 5'h11 && !lock) begin m_h = reg_wdata[5:0]; m_sbd = reg_wdata[6]; end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R7 win_start", win_start, m_ws);
      chk("R2 disp_en", disp_en, m_ge);
      chk("R9 vsa_bad", vsa_bad, m_v == 0);
      chk("R3 bg_fringe", bg_fringe, m_fr);
      chk("R4 bg_space_en", bg_space_en, !m_sbd);
      chk("R10 ram_grant", ram_grant, ram_req && !m_ge);
      if (win_start) strobes++;
    end
  end

  task automatic wr(input logic [2:0] pg, input logic [4:0] ad, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_page = pg; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic frame(input int nlines);
    strobes = 0;
    @(negedge clk); vsync = 1'b1;
    repeat (3) @(negedge clk);
    vsync = 1'b0;
    repeat (5) @(negedge clk);
    for (int l = 0; l < nlines; l++) begin
      hsync = 1'b1;
      repeat (4) @(negedge clk);
      hsync = 1'b0;
      repeat (LINE_LEN - 4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_window(input int v, input int h, input bit fr, input bit sbd);
    wr(3'd6, 5'h17, 8'h00);
    wr(3'd6, 5'h10, {1'b0, fr, v[5:0]});
    wr(3'd6, 5'h11, {1'b0, sbd, h[5:0]});
    wr(3'd6, 5'h17, 8'h01);
    frame(4 * v + 3);
    chk("R6 one strobe per frame", strobes, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 disp_en", disp_en, 0);
    chk("R1 vsa_bad", vsa_bad, 1);
    chk("R1 bg_fringe", bg_fringe, 0);
    chk("R1 bg_space_en", bg_space_en, 1);
    chk("R1 win_start", win_start, 0);
    chk("R1 ram_grant", ram_grant, 0);

    run_window(1, 0, 1'b1, 1'b0);
    chk("R3 fringe set", bg_fringe, 1);
    // locked writes
    wr(3'd6, 5'h10, 8'h05);
    wr(3'd6, 5'h11, 8'h45);
    #2;
    chk("R3 locked vertical", bg_fringe, 1);
    chk("R4 locked horizontal", bg_space_en, 1);
    ram_req = 1'b1;
    @(negedge clk); #2;
    chk("R10 ram blocked", ram_grant, 0);
    wr(3'd6, 5'h17, 8'h00);
    #2;
    chk("R2 clear while locked", disp_en, 0);
    chk("R10 ram granted", ram_grant, 1);
    ram_req = 1'b0;

    run_window(5, 5, 1'b0, 1'b1);
    chk("R4 space blank", bg_space_en, 0);
    run_window(16, 63, 1'b1, 1'b0);
    run_window(3, 17, 1'b0, 1'b0);

    // foreign writes
    wr(3'd6, 5'h17, 8'h00);
    wr(3'd5, 5'h10, 8'h40);
    wr(3'd6, 5'h12, 8'h01);
    wr(3'd6, 5'h16, 8'h01);
    #2;
    chk("R5 foreign page", bg_fringe, 0);
    chk("R5 foreign offset", disp_en, 0);

    // display off: no strobe
    frame(15);
    chk("R8 no strobe when off", strobes, 0);

    // zero vertical start
    wr(3'd6, 5'h10, 8'h00);
    #2;
    chk("R9 zero flagged", vsa_bad, 1);
    wr(3'd6, 5'h17, 8'h01);
    frame(10);
    chk("R9 no strobe at zero", strobes, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule